// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines into a single request towards a processor. Each source owns an 8-bit priority level; a level of zero keeps the source out of arbitration altogether. A source competes only when its line is high (or its force bit is set), it has a nonzero level, and its mask bit is clear. Among the competitors the highest level wins, and a tie goes to the higher source number. The block presents the winner's level, a vector equal to 64 plus the winner's number, and a request flag. When nothing competes it presents level 0 and the fixed spurious vector 24.

Software reaches the block over a plain synchronous 32-bit register bus with an 8-bit offset. Read data is combinational on the offset. A write takes effect on the clock edge where `bus_wr` is high. The 64-bit pending, mask and force words each occupy two 32-bit offsets. The per-source levels occupy one byte offset each. A read-only location returns the vector currently being presented, so software can acknowledge without a dedicated bus cycle.

Top module: `prio_intc`

## Requirements
- R1: Pending bit n takes the level of `irq_in[n]` at every clock edge. It reads at offset 0x00 (bits 63:32) and 0x04 (bits 31:0). Writes to those two offsets change nothing and raise no error.
- R2: A source competes only when (pending OR force) AND enabled AND NOT masked. With every mask bit set, `irq_req` stays low.
- R3: A write to offset 0x40+n stores `bus_wdata[7:0]` as the level of source n. A nonzero level enables the source and zero disables it. The level reads back zero-extended at the same offset.
- R4: The winner is the competing source with the largest level. On equal levels the larger source number wins.
- R5: While a source wins, `irq_req` is 1, `irq_level` is that source's level and `irq_vector` is 64 plus its number. With no winner, `irq_req` is 0, `irq_level` is 0 and `irq_vector` is 24.
- R6: Offset 0x08 holds mask bits 63:32 and 0x0C holds bits 31:0. A write to either replaces only that half.
- R7: After reset every mask bit is 1. Pending, force and all levels are 0, and the vector is 24.
- R8: Offset 0xE0 reads the presented vector. Offsets 0x10/0x14 read the force halves. Every other offset outside the map reads 0.
- R9: A write to any offset other than 0x00, 0x04, 0x08, 0x0C or 0x40..0x7F changes no state. It drives `bus_err` high for exactly the one cycle after the write edge.
- R10: Outputs are registered. A register write shows at the outputs one edge after the write edge. A change on `irq_in` shows two edges after it is applied: one edge into pending, one into the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 64 | Level-sensitive request lines, bit n is source n |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| bus_err | output | 1 | One-cycle pulse after a write to a non-writable offset |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_level | output | 8 | Level of the winning source |
| irq_vector | output | 8 | Vector of the winning source, or 24 |

## Verification
The properties assume that `irq_in`, `bus_wr` and `bus_addr` are quiet while reset is held. This matters because the pending read-back check compares against the request lines one cycle earlier. The bench therefore holds every request line low and the bus idle until reset has cleared the internal synchronizer. The error-pulse properties assume `bus_wr` is a clean single-cycle strobe sampled at the edge. The bench asserts it for exactly one edge per write, drives all inputs on the falling edge, and returns the offset to an unmapped idle value between accesses.

// File: rtl/prio_intc_pkg.sv
`timescale 1ns/1ps
package prio_intc_pkg;
  localparam int unsigned SRC_CNT = 64;
  localparam int unsigned LVL_W   = 8;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned OFS_W   = 8;
  localparam int unsigned VEC_W   = 8;

  localparam int unsigned VEC_BASE = 64;
  localparam int unsigned VEC_SPUR = 24;

  localparam logic [OFS_W-1:0] OFS_PEND_HI  = 8'h00;
  localparam logic [OFS_W-1:0] OFS_PEND_LO  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_MASK_HI  = 8'h08;
  localparam logic [OFS_W-1:0] OFS_MASK_LO  = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_FRC_HI   = 8'h10;
  localparam logic [OFS_W-1:0] OFS_FRC_LO   = 8'h14;
  localparam logic [OFS_W-1:0] OFS_LVL_BASE = 8'h40;
  localparam logic [OFS_W-1:0] OFS_VEC      = 8'hE0;
endpackage

// File: rtl/prio_intc_regs.sv
`timescale 1ns/1ps
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int unsigned N  = SRC_CNT,
  parameter int unsigned LW = LVL_W,
  parameter int unsigned DW = BUS_W,
  parameter int unsigned VW = VEC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          irq_in,
  input  logic                  wr_en,
  input  logic [OFS_W-1:0]      addr,
  input  logic [DW-1:0]         wdata,
  input  logic [VW-1:0]         vec_cur,
  output logic [DW-1:0]         rdata,
  output logic                  wr_err,
  output logic [N-1:0]          pend_o,
  output logic [N-1:0]          mask_o,
  output logic [N-1:0]          frc_o,
  output logic [N-1:0][LW-1:0]  lvl_o
);
  localparam int unsigned IW = $clog2(N);
  localparam int unsigned LO = 32'(OFS_LVL_BASE);

  logic [N-1:0]         pend_q;
  logic [N-1:0]         mask_q, mask_d;
  logic                 mask_we;
  logic [N-1:0]         frc_q;
  logic [N-1:0][LW-1:0] lvl_q, lvl_d;
  logic                 lvl_we;
  logic                 err_q, err_d;

  logic                 lvl_hit;
  logic [IW-1:0]        lvl_idx;
  logic                 ofs_writable;

  assign lvl_hit = (32'(addr) >= LO) && (32'(addr) < LO + N);
  assign lvl_idx = IW'(32'(addr) - LO);
  assign ofs_writable = lvl_hit || (addr == OFS_PEND_HI) || (addr == OFS_PEND_LO) ||
                        (addr == OFS_MASK_HI) || (addr == OFS_MASK_LO);

  // next-state
  always_comb begin
    mask_d  = mask_q;
    mask_we = 1'b0;
    if (wr_en && addr == OFS_MASK_HI) begin
      mask_d[N-1:DW] = wdata;
      mask_we        = 1'b1;
    end
    if (wr_en && addr == OFS_MASK_LO) begin
      mask_d[DW-1:0] = wdata;
      mask_we        = 1'b1;
    end
  end

  always_comb begin
    lvl_d  = lvl_q;
    lvl_we = wr_en && lvl_hit;
    if (lvl_we) lvl_d[lvl_idx] = wdata[LW-1:0];
  end

  assign err_d = wr_en && !ofs_writable;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      frc_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= irq_in;
      frc_q  <= frc_q;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_we) lvl_q <= lvl_d;
  end

  // read path
  always_comb begin
    rdata = '0;
    if (lvl_hit) rdata = DW'(lvl_q[lvl_idx]);
    else begin
      case (addr)
        OFS_PEND_HI: rdata = pend_q[N-1:DW];
        OFS_PEND_LO: rdata = pend_q[DW-1:0];
        OFS_MASK_HI: rdata = mask_q[N-1:DW];
        OFS_MASK_LO: rdata = mask_q[DW-1:0];
        OFS_FRC_HI:  rdata = frc_q[N-1:DW];
        OFS_FRC_LO:  rdata = frc_q[DW-1:0];
        OFS_VEC:     rdata = DW'(vec_cur);
        default:     rdata = '0;
      endcase
    end
  end

  assign wr_err = err_q;
  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign frc_o  = frc_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/prio_intc_arb.sv
`timescale 1ns/1ps
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int unsigned N  = SRC_CNT,
  parameter int unsigned LW = LVL_W,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]         act,
  input  logic [N-1:0][LW-1:0] lvl,
  output logic                 win_vld,
  output logic [LW-1:0]        win_lvl,
  output logic [IW-1:0]        win_idx
);
  // Balanced tree; N must be a power of two. The upper child of each pair
  // holds the larger indices and wins on an equal level.
  for (genvar s = 0; s <= IW; s++) begin : g_st
    localparam int unsigned W = N >> s;
    logic [W-1:0]  vld;
    logic [LW-1:0] lv [W];
    logic [IW-1:0] ix [W];

    if (s == 0) begin : g_leaf
      for (genvar i = 0; i < W; i++) begin : g_i
        assign vld[i] = act[i];
        assign lv[i]  = lvl[i];
        assign ix[i]  = IW'(i);
      end
    end else begin : g_node
      for (genvar i = 0; i < W; i++) begin : g_i
        logic pick_hi;
        assign pick_hi = g_st[s-1].vld[2*i+1] &&
                         (!g_st[s-1].vld[2*i] || (g_st[s-1].lv[2*i+1] >= g_st[s-1].lv[2*i]));
        assign vld[i] = g_st[s-1].vld[2*i] | g_st[s-1].vld[2*i+1];
        assign lv[i]  = pick_hi ? g_st[s-1].lv[2*i+1] : g_st[s-1].lv[2*i];
        assign ix[i]  = pick_hi ? g_st[s-1].ix[2*i+1] : g_st[s-1].ix[2*i];
      end
    end
  end

  assign win_vld = g_st[IW].vld[0];
  assign win_lvl = g_st[IW].lv[0];
  assign win_idx = g_st[IW].ix[0];
endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int unsigned N  = SRC_CNT,
  parameter int unsigned LW = LVL_W,
  parameter int unsigned DW = BUS_W,
  parameter int unsigned VW = VEC_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [N-1:0]     irq_in,
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_err,
  output logic             irq_req,
  output logic [LW-1:0]    irq_level,
  output logic [VW-1:0]    irq_vector
);
  localparam int unsigned IW = $clog2(N);

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [N-1:0]         pend, mask, frc;
  logic [N-1:0][LW-1:0] lvl;
  logic [N-1:0]         en, act;
  logic                 win_vld;
  logic [LW-1:0]        win_lvl;
  logic [IW-1:0]        win_idx;

  logic          req_q, req_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [VW-1:0] vec_q, vec_d;

  prio_intc_regs #(.N(N), .LW(LW), .DW(DW), .VW(VW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .vec_cur (vec_q),
    .rdata   (bus_rdata),
    .wr_err  (bus_err),
    .pend_o  (pend),
    .mask_o  (mask),
    .frc_o   (frc),
    .lvl_o   (lvl)
  );

  for (genvar i = 0; i < N; i++) begin : g_en
    assign en[i] = |lvl[i];
  end
  assign act = (pend | frc) & en & ~mask;

  prio_intc_arb #(.N(N), .LW(LW), .IW(IW)) u_arb (
    .act     (act),
    .lvl     (lvl),
    .win_vld (win_vld),
    .win_lvl (win_lvl),
    .win_idx (win_idx)
  );

  // next-state
  always_comb begin
    req_d = win_vld;
    lvl_d = win_vld ? win_lvl : '0;
    vec_d = win_vld ? (VW'(VEC_BASE) + VW'(win_idx)) : VW'(VEC_SPUR);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= '0;
      vec_q <= VW'(VEC_SPUR);
    end else begin
      req_q <= req_d;
      lvl_q <= lvl_d;
      vec_q <= vec_d;
    end
  end

  assign irq_req    = req_q;
  assign irq_level  = lvl_q;
  assign irq_vector = vec_q;
endmodule

// File: rtl/prio_intc_chk.sv
`timescale 1ns/1ps
module prio_intc_chk
  import prio_intc_pkg::*;
#(
  parameter int unsigned N  = SRC_CNT,
  parameter int unsigned LW = LVL_W,
  parameter int unsigned DW = BUS_W,
  parameter int unsigned VW = VEC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     irq_in,
  input logic             bus_wr,
  input logic [OFS_W-1:0] bus_addr,
  input logic [DW-1:0]    bus_rdata,
  input logic             bus_err,
  input logic             irq_req,
  input logic [LW-1:0]    irq_level,
  input logic [VW-1:0]    irq_vector,
  input logic [N-1:0]     mask
);
  localparam int unsigned LO = 32'(OFS_LVL_BASE);
  logic wr_bad;
  assign wr_bad = bus_wr && !((32'(bus_addr) >= LO && 32'(bus_addr) < LO + N) ||
                  bus_addr == OFS_PEND_HI || bus_addr == OFS_PEND_LO ||
                  bus_addr == OFS_MASK_HI || bus_addr == OFS_MASK_LO);

  // R5
  req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (irq_level != '0));
  // R5
  idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vector == VW'(VEC_SPUR));
  // R5
  vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (32'(irq_vector) >= VEC_BASE && 32'(irq_vector) < VEC_BASE + N));
  // R1
  pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == OFS_PEND_LO |-> bus_rdata == $past(irq_in[DW-1:0]));
  // R2
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(mask)) |-> !irq_req);
  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(wr_bad));
  // R9
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> bus_err);
endmodule

bind prio_intc prio_intc_chk #(.N(N), .LW(LW), .DW(DW), .VW(VW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_in     (irq_in),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_err    (bus_err),
  .irq_req    (irq_req),
  .irq_level  (irq_level),
  .irq_vector (irq_vector),
  .mask       (mask)
);

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [63:0] irq_in;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        irq_req;
  logic [7:0]  irq_level;
  logic [7:0]  irq_vector;

  always #10 clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rst_ni(rst_ni), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_req(irq_req), .irq_level(irq_level),
    .irq_vector(irq_vector)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] mask_m;
  logic [7:0]  lvl_m [64];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // reference scan: low to high index, greater-or-equal replaces
  task automatic ref_scan(output logic rq, output logic [7:0] lv, output logic [7:0] vec);
    int best = 64;
    logic [7:0] bl = 0;
    for (int i = 0; i < 64; i++) begin
      if (irq_in[i] && lvl_m[i] != 0 && !mask_m[i] && lvl_m[i] >= bl) begin
        bl = lvl_m[i];
        best = i;
      end
    end
    rq  = (best != 64);
    lv  = bl;
    vec = rq ? 8'(64 + best) : 8'd24;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    err = bus_err;
    bus_wr = 1'b0; bus_addr = 8'hFF; bus_wdata = '0;
    if (a == 8'h08) mask_m[63:32] = d;
    if (a == 8'h0C) mask_m[31:0] = d;
    if (a >= 8'h40 && a < 8'h80) lvl_m[a - 8'h40] = d[7:0];
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 8'hFF;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmp_outputs(input string req);
    logic rq; logic [7:0] lv, vec;
    ref_scan(rq, lv, vec);
    chk({req, " req"}, 32'(irq_req), 32'(rq));
    chk({req, " level"}, 32'(irq_level), 32'(lv));
    chk({req, " vector"}, 32'(irq_vector), 32'(vec));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R7 req", 32'(irq_req), 0);
    chk("R7 vector", 32'(irq_vector), 24);
    chk("R7 level", 32'(irq_level), 0);
    rd(8'h08, d); chk("R7 mask hi", d, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R7 mask lo", d, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R7 pend lo", d, 0);
    rd(8'h7F, d); chk("R7 level reg", d, 0);
    rd(8'h14, d); chk("R7 force lo", d, 0);
    rd(8'hE0, d); chk("R8 vector read reset", d, 24);
  endtask

  task automatic t_basic();
    logic e; logic [31:0] d;
    irq_in = 64'h0000_0001_0000_0020;
    wr(8'h0C, 32'h0, e);
    settle();
    chk("R3 level zero keeps out req", 32'(irq_req), 0);
    wr(8'h45, 32'hABCD_0003, e);
    rd(8'h45, d); chk("R3 level readback", d, 32'h03);
    settle();
    chk("R5 single source vector", 32'(irq_vector), 69);
    chk("R5 single source level", 32'(irq_level), 3);
    cmp_outputs("R5");
    wr(8'h60, 32'h9, e);          // source 32 masked by upper half
    settle();
    chk("R2 masked source loses", 32'(irq_vector), 69);
    rd(8'h04, d); chk("R1 pend lo", d, 32'h20);
    rd(8'h00, d); chk("R1 pend hi", d, 32'h1);
    wr(8'h04, 32'h0, e);
    chk("R1 pend write no error", 32'(e), 0);
    rd(8'h04, d); chk("R1 pend write ignored", d, 32'h20);
  endtask

  task automatic t_mask_halves();
    logic e; logic [31:0] d;
    wr(8'h08, 32'h0, e);
    rd(8'h0C, d); chk("R6 lower half kept", d, 32'h0);
    rd(8'h08, d); chk("R6 upper half written", d, 32'h0);
    settle();
    chk("R4 higher level wins", 32'(irq_vector), 96);
    cmp_outputs("R4");
    wr(8'h0C, 32'hFFFF_FFFF, e);
    rd(8'h08, d); chk("R6 upper half kept", d, 32'h0);
    wr(8'h0C, 32'h0, e);
  endtask

  task automatic t_ties();
    logic e;
    irq_in = 64'h8000_0100_0000_0408;
    wr(8'h4A, 32'h4, e);
    wr(8'h68, 32'h4, e);
    wr(8'h60, 32'h0, e);
    wr(8'h45, 32'h0, e);
    settle();
    chk("R4 tie larger index", 32'(irq_vector), 104);
    wr(8'h43, 32'h7, e);
    settle();
    chk("R4 top level low index", 32'(irq_vector), 67);
    wr(8'h7F, 32'h7, e);
    settle();
    chk("R4 tie at top level", 32'(irq_vector), 127);
    wr(8'h43, 32'h0, e);
    wr(8'h7F, 32'h0, e);
    settle();
    chk("R3 disable by zero write", 32'(irq_vector), 104);
    cmp_outputs("R3");
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(8'h20, d); chk("R8 unmapped 0x20", d, 0);
    rd(8'hE4, d); chk("R8 unmapped 0xE4", d, 0);
    rd(8'h10, d); chk("R8 force hi", d, 0);
    rd(8'hE0, d); chk("R8 vector read", d, 32'(irq_vector));
  endtask

  task automatic t_bad_write();
    logic e; logic [31:0] d;
    wr(8'h20, 32'hFFFF_FFFF, e);
    chk("R9 error pulse", 32'(e), 1);
    @(posedge clk); @(negedge clk);
    chk("R9 error one cycle", 32'(bus_err), 0);
    wr(8'hE0, 32'h55, e);
    chk("R9 error on vector write", 32'(e), 1);
    rd(8'hE0, d); chk("R9 vector unchanged", d, 104);
    wr(8'h10, 32'hFFFF_FFFF, e);
    chk("R9 error on force write", 32'(e), 1);
    rd(8'h10, d); chk("R9 force unchanged", d, 0);
    wr(8'h0C, 32'h0, e);
    chk("R9 no error on mask write", 32'(e), 0);
    settle();
    chk("R9 outputs unchanged", 32'(irq_vector), 104);
  endtask

  task automatic t_timing();
    logic e;
    @(negedge clk);
    irq_in[63] = 1'b1;
    wr(8'h7F, 32'h9, e);          // 2 negedges pass inside
    chk("R10 not yet after write edge", 32'(irq_vector), 104);
    @(posedge clk); @(negedge clk);
    chk("R10 one edge after write", 32'(irq_vector), 127);
    irq_in[63] = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 input one edge", 32'(irq_vector), 127);
    @(posedge clk); @(negedge clk);
    chk("R10 input two edges", 32'(irq_vector), 104);
  endtask

  task automatic t_all_masked();
    logic e;
    irq_in = '1;
    wr(8'h08, 32'hFFFF_FFFF, e);
    wr(8'h0C, 32'hFFFF_FFFF, e);
    settle();
    chk("R2 all masked req", 32'(irq_req), 0);
    chk("R5 idle vector", 32'(irq_vector), 24);
    chk("R5 idle level", 32'(irq_level), 0);
  endtask

  task automatic t_sweep();
    logic e;
    logic [31:0] s = 32'h1234_5678;
    for (int i = 0; i < 64; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      wr(8'(8'h40 + i), {29'd0, s[31:29]}, e);
    end
    for (int k = 0; k < 24; k++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      irq_in[31:0] = s;
      s = s * 32'd1664525 + 32'd1013904223;
      irq_in[63:32] = s;
      s = s * 32'd1664525 + 32'd1013904223;
      wr(8'h08, s & 32'h5A5A_0F0F, e);
      wr(8'h0C, s & 32'h3C3C_F00F, e);
      settle();
      cmp_outputs("R4 R5 sweep");
    end
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; irq_in = '0; bus_wr = 1'b0; bus_addr = 8'hFF; bus_wdata = '0;
    mask_m = '1;
    for (int i = 0; i < 64; i++) lvl_m[i] = 8'd0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_mask_halves();
    t_ties();
    t_unmapped();
    t_bad_write();
    t_timing();
    t_all_masked();
    t_sweep();
    summary();
    $finish;
  end
endmodule